// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block watches the live BCD time of a real-time clock (seconds, minutes, hours, weekday, day of month and month) and raises an alarm when the time matches a programmed set of fields. Each of the six alarm bytes holds its own compare enable, so software can build an alarm from any subset of fields: for example a seconds value alone makes the alarm fire once a minute.

The time counters live outside the block. Their values arrive on the time inputs, and a one-cycle strobe marks every seconds update. The block checks for a match only on that strobe. On a match it sets a sticky alarm flag. It drives the interrupt line while both the flag and the alarm interrupt enable are set. A small register port gives read and write access to the alarm bytes and to a control byte that holds the flag and the enable.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset every alarm byte reads 0x00, the control byte reads 0x00 and `alarm_irq_o` is low.
- R2: A write to address 0 (seconds), 1 (minutes), 2 (hours), 3 (weekday), 4 (day of month) or 5 (month, 1 to 12) stores the full byte, and a read of that address returns it.
- R3: In an alarm byte, bit 7 is the compare enable and bits 6:0 hold the BCD value. A field whose bit 7 is 1 matches when bits 6:0 equal the corresponding 7-bit time input. A field whose bit 7 is 0 takes no part in the match.
- R4: When all six enable bits are 0, the flag is never set, whatever the time inputs are.
- R5: A match is evaluated only in a cycle with `tick_i` high. The flag reads 1 from the cycle after that edge. A matching time without `tick_i` leaves the flag unchanged.
- R6: Once set, the flag stays set when later ticks do not match, until software clears it.
- R7: The control byte sits at address 6 and reads as {4'b0, enable, 2'b0, flag}, with the flag in bit 0 and the interrupt enable in bit 3. Writing it loads bit 3 into the enable. Writing 0 in bit 0 clears the flag. Writing 1 in bit 0 leaves the flag unchanged.
- R8: When a tick finds a match in the same cycle as a control write that clears the flag, the flag ends up set.
- R9: `alarm_irq_o` is high exactly when the flag and the interrupt enable are both 1.
- R10: Address 7 reads 0x00, and a write to it changes no alarm byte and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe for each seconds update |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| wday_i | input | 7 | Current weekday, BCD |
| mday_i | input | 7 | Current day of month, BCD |
| mon_i | input | 7 | Current month 1 to 12, BCD |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The bound assertions check the following on every cycle:
- the flag rises only one edge after a tick;
- the flag holds unless a clear write arrives;
- a clear write without a simultaneous match clears the flag;
- a match wins over a simultaneous clear;
- a tick with no enabled field cannot raise the flag;
- the interrupt never rises without both the flag and the enable.

Other behaviours can only be shown by the bench's scenarios:
- how the per-field masking picks which fields must be equal;
- the read-back of every alarm byte;
- the layout of the control byte;
- that address 7 is ignored.

The bench shows these through random field enables, time vectors biased toward matches, and directed corner cases.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BYTE_W     = 8;
  localparam int VAL_W      = 7;
  localparam int ADDR_W     = 3;
  localparam int EN_BIT     = 7;
  localparam int FLAG_BIT   = 0;
  localparam int AIE_BIT    = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

  typedef logic [BYTE_W-1:0] alarm_byte_t;
  typedef logic [VAL_W-1:0]  bcd_val_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_FIELDS-1:0]      wr_en_i,
  input  alarm_byte_t                wdata_i,
  output alarm_byte_t [NUM_FIELDS-1:0] alarm_o
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         alarm_o[g] <= '0;
      else if (wr_en_i[g]) alarm_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  alarm_byte_t [NUM_FIELDS-1:0] alarm_i,
  input  bcd_val_t    [NUM_FIELDS-1:0] time_i,
  output logic        [NUM_FIELDS-1:0] en_o,
  output logic                         match_o
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign en_o[g] = alarm_i[g][EN_BIT];
    // disabled field always counts as hit
    assign hit[g]  = !en_o[g] || (alarm_i[g][VAL_W-1:0] == time_i[g]);
  end

  assign match_o = (|en_o) && (&hit);
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic ctrl_we_i,
  input  logic flag_wbit_i,
  input  logic aie_wbit_i,
  output logic flag_o,
  output logic aie_o
);
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (ctrl_we_i && !flag_wbit_i) flag_d = 1'b0;
    if (tick_i && match_i)         flag_d = 1'b1;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      aie_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      if (ctrl_we_i) aie_o <= aie_wbit_i;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [VAL_W-1:0]  sec_i,
  input  logic [VAL_W-1:0]  min_i,
  input  logic [VAL_W-1:0]  hour_i,
  input  logic [VAL_W-1:0]  wday_i,
  input  logic [VAL_W-1:0]  mday_i,
  input  logic [VAL_W-1:0]  mon_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              alarm_irq_o
);
  alarm_byte_t [NUM_FIELDS-1:0] alarm_q;
  bcd_val_t    [NUM_FIELDS-1:0] time_vec;
  logic        [NUM_FIELDS-1:0] wr_field;
  logic        [NUM_FIELDS-1:0] en_vec;
  logic                         match;
  logic                         ctrl_we;
  logic                         flag_q;
  logic                         aie_q;

  assign time_vec = {mon_i, mday_i, wday_i, hour_i, min_i, sec_i};

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
    assign wr_field[g] = reg_we_i && (reg_addr_i == ADDR_W'(g));
  end
  assign ctrl_we = reg_we_i && (reg_addr_i == CTRL_ADDR);

  rtc_alarm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_field),
    .wdata_i (reg_wdata_i),
    .alarm_o (alarm_q)
  );

  rtc_alarm_cmp u_cmp (
    .alarm_i (alarm_q),
    .time_i  (time_vec),
    .en_o    (en_vec),
    .match_o (match)
  );

  rtc_alarm_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .match_i     (match),
    .ctrl_we_i   (ctrl_we),
    .flag_wbit_i (reg_wdata_i[FLAG_BIT]),
    .aie_wbit_i  (reg_wdata_i[AIE_BIT]),
    .flag_o      (flag_q),
    .aie_o       (aie_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = alarm_q[i];
    if (reg_addr_i == CTRL_ADDR) begin
      reg_rdata_o[FLAG_BIT] = flag_q;
      reg_rdata_o[AIE_BIT]  = aie_q;
    end
  end

  assign alarm_irq_o = flag_q && aie_q;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic                  reg_we_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic                  clr_bit,
  input logic                  match,
  input logic [NUM_FIELDS-1:0] en_vec,
  input logic                  flag_q,
  input logic                  aie_q,
  input logic                  alarm_irq_o
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == CTRL_ADDR) && !clr_bit;

  p_set_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i));

  p_all_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) && !flag_q |=> !flag_q);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_wr |=> flag_q);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !(tick_i && match) |=> !flag_q);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && tick_i && match |=> flag_q);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> flag_q && aie_q);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .clr_bit     (reg_wdata_i[0]),
  .match       (match),
  .en_vec      (en_vec),
  .flag_q      (flag_q),
  .aie_q       (aie_q),
  .alarm_irq_o (alarm_irq_o)
);

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] tm [6];
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       alarm_irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_alarm [6];
  logic       m_flag, m_aie;

  always #2 clk_i = ~clk_i;

  rtc_alarm_match dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .sec_i(tm[0]), .min_i(tm[1]), .hour_i(tm[2]),
    .wday_i(tm[3]), .mday_i(tm[4]), .mon_i(tm[5]),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .alarm_irq_o(alarm_irq_o)
  );

  function automatic logic exp_match();
    logic any = 1'b0;
    logic all = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (m_alarm[i][7]) begin
        any = 1'b1;
        if (m_alarm[i][6:0] != tm[i]) all = 1'b0;
      end
    end
    return any && all;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    if (a < 3'd6) return m_alarm[a];
    if (a == 3'd6) return {4'b0, m_aie, 2'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a < 3'd6) m_alarm[a] = d;
    else if (a == 3'd6) begin m_flag = m_flag & d[0]; m_aie = d[3]; end
  endtask

  task automatic rd_check(input string req, input logic [2:0] a);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check8(req, reg_rdata_o, exp_read(a));
  endtask

  task automatic check_state(input string req);
    rd_check(req, 3'd6);
    check8({req, " irq"}, {7'b0, alarm_irq_o}, {7'b0, m_flag & m_aie});
  endtask

  // tick with optional simultaneous control write
  task automatic do_tick(input logic with_wr, input logic [7:0] cw);
    logic mt;
    @(negedge clk_i);
    tick_i = 1'b1;
    if (with_wr) begin reg_we_i = 1'b1; reg_addr_i = 3'd6; reg_wdata_i = cw; end
    mt = exp_match();
    @(negedge clk_i);
    tick_i = 1'b0; reg_we_i = 1'b0;
    if (with_wr) begin m_flag = m_flag & cw[0]; m_aie = cw[3]; end
    if (mt) m_flag = 1'b1;
  endtask

  task automatic set_time_rand(input int bias);
    for (int i = 0; i < 6; i++)
      tm[i] = (($urandom % 100) < bias) ? m_alarm[i][6:0] : 7'($urandom);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) begin m_alarm[i] = '0; tm[i] = '0; end
    m_flag = 1'b0; m_aie = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) rd_check("R1", 3'(a));
    check_state("R1");

    // R2 read-back of each field
    for (int a = 0; a < 6; a++) begin
      wr(3'(a), 8'h5A ^ 8'(a * 17));
      rd_check("R2", 3'(a));
    end

    // R4 all fields disabled, time equal to values
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h00);
    for (int i = 0; i < 6; i++) tm[i] = 7'h00;
    do_tick(1'b0, 8'h00);
    check_state("R4");

    // R3 seconds only enabled
    wr(3'd0, 8'hB0);
    set_time_rand(0); tm[0] = 7'h31;
    do_tick(1'b0, 8'h00);
    check_state("R3 mismatch");
    tm[0] = 7'h30;
    // R5 matching time without tick
    repeat (4) @(negedge clk_i);
    check_state("R5 no tick");
    do_tick(1'b0, 8'h00);
    check_state("R3 match");

    // R6 sticky after mismatch
    tm[0] = 7'h45;
    do_tick(1'b0, 8'h00);
    check_state("R6");

    // R7 write 1 in flag bit keeps flag, enable loads; R9 irq
    wr(3'd6, 8'h09);
    check_state("R7 keep");
    check8("R9", {7'b0, alarm_irq_o}, 8'h01);
    wr(3'd6, 8'h08);
    check_state("R7 clear");
    check8("R9 low", {7'b0, alarm_irq_o}, 8'h00);

    // R8 set beats clear
    tm[0] = 7'h30;
    do_tick(1'b1, 8'h08);
    check_state("R8");
    check8("R8 flag", {7'b0, m_flag}, 8'h01);

    // R10 address 7
    wr(3'd7, 8'hFF);
    rd_check("R10", 3'd7);
    for (int a = 0; a < 7; a++) rd_check("R10", 3'(a));

    // month field 1..12 with hour, others off
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h00); wr(3'd2, 8'h80 | 8'h23); wr(3'd5, 8'h80 | 8'h12);
    tm[2] = 7'h23; tm[5] = 7'h11;
    do_tick(1'b0, 8'h00);
    check_state("R3 month");
    tm[5] = 7'h12;
    do_tick(1'b0, 8'h00);
    check_state("R3 month match");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 5);
      case (op)
        0: wr(3'($urandom % 6), {1'($urandom), 7'($urandom)});
        1: begin set_time_rand(80); do_tick(1'b0, 8'h00); end
        2: wr(3'd6, 8'($urandom));
        3: begin set_time_rand(90); do_tick(1'b1, 8'($urandom)); end
        default: rd_check("R2", 3'($urandom % 8));
      endcase
      check_state("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule